// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked system and an asynchronous static RAM of 128K words by 24 bits. It accepts one read or write request at a time on a valid/ready port and turns it into pin sequences for the memory: a 17-bit address, three chip-select pins of mixed polarity, a write strobe, an output-enable strobe, and control of a tri-state driver on the shared 24-bit data bus. Read data comes back on a separate port with a one-cycle valid pulse.

Every memory timing limit is a parameter in nanoseconds. Each limit is turned into a count of system clock cycles, rounded up, against the clock period parameter `CLK_NS`. The parameter `KEEP_OE_LOW` selects one of two write styles. With `KEEP_OE_LOW` = 0, output enable stays high during a write and the shorter write pulse applies. With `KEEP_OE_LOW` = 1, output enable stays low during a write. The pulse is then stretched to the longer minimum, and the data driver waits until the memory has released the bus.

States: `ST_IDLE` (ready, accepts a request), `ST_RD_ACC` (read access, output enable low), `ST_RD_FLOAT` (selects off, waiting for the memory to float the bus), `ST_TURN` (a single dead cycle before a write that follows a read), `ST_WR_PULSE` (write strobe low), `ST_WR_HOLD` (strobe and selects released, data still driven). The transitions are:
- `ST_IDLE`→`ST_RD_ACC` on an accepted read.
- `ST_IDLE`→`ST_WR_PULSE` on an accepted write when the last access was not a read.
- `ST_IDLE`→`ST_TURN` on an accepted write when the last access was a read.
- `ST_TURN`→`ST_WR_PULSE` after one cycle.
- `ST_RD_ACC`→`ST_RD_FLOAT` on the last access cycle.
- `ST_RD_FLOAT`→`ST_IDLE` on the last float cycle.
- `ST_WR_PULSE`→`ST_WR_HOLD` on the last pulse cycle.
- `ST_WR_HOLD`→`ST_IDLE` after one cycle.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset the block is ready. The selects are inactive (`mem_ce1_n`=1, `mem_ce2`=0, `mem_ce3_n`=1), `mem_we_n`=1, `mem_oe_n`=1, the data driver is off and `rsp_valid`=0.
- R2: The three select pins always agree. Active means `mem_ce1_n`=0, `mem_ce2`=1 and `mem_ce3_n`=0 together. They are active only in the read access cycles and the write pulse cycles.
- R3: `mem_we_n` goes low only while the selects are active. A word that is written can be read back unchanged from the same address.
- R4: `mem_addr` holds the accepted address without change from the first cycle of an access to its last driven cycle.
- R5: A read holds `mem_oe_n` low and `mem_we_n` high for ceil(T_AA_NS/CLK_NS) cycles (3 with defaults). `mem_dq_i` is sampled on the last of these cycles. `rsp_valid` is a one-cycle pulse in the next cycle, carrying that data.
- R6: With `KEEP_OE_LOW`=0, a write holds `mem_oe_n` high. `mem_we_n` stays low for max(ceil(T_WP_NS/CLK_NS), ceil(T_DW_NS/CLK_NS)) cycles (2 with defaults). The driver is on for the whole pulse and for exactly one hold cycle after it, in which `mem_we_n` is high.
- R7: With `KEEP_OE_LOW`=1, `mem_oe_n` stays low through the write. The pulse lasts max(ceil(T_WP1_NS/CLK_NS), ceil(T_WHZ_NS/CLK_NS)+ceil(T_DW_NS/CLK_NS)) cycles (4 with defaults). The driver turns on only from pulse cycle ceil(T_WHZ_NS/CLK_NS), counted from 0 (cycle 2 with defaults).
- R8: The driver is never on while the memory may drive the bus (`mem_oe_n` low with `mem_we_n` high). After a read, `mem_oe_n` stays high for ceil(T_OHZ_NS/CLK_NS) cycles (2 with defaults) before the block is ready again.
- R9: A write accepted when the previous access was a read waits one turnaround cycle before `mem_we_n` falls. Otherwise `mem_we_n` falls in the cycle right after acceptance.
- R10: `req_ready` is low from the cycle after acceptance until the sequence ends. A write never raises `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (17) | Word address |
| req_wdata | input | DW (24) | Write data |
| rsp_valid | output | 1 | One-cycle pulse, read data valid |
| rsp_rdata | output | DW (24) | Read data |
| mem_addr | output | AW (17) | Memory address pins |
| mem_ce1_n | output | 1 | Select 1, active low |
| mem_ce2 | output | 1 | Select 2, active high |
| mem_ce3_n | output | 1 | Select 3, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_o | output | DW (24) | Data toward the memory |
| mem_dq_oe | output | 1 | Enable for the tri-state data driver |
| mem_dq_i | input | DW (24) | Data from the memory bus |

## Verification
The bound checker watches, on every cycle, these properties:
- the three selects agree;
- the write strobe falls only under an active select;
- the driver is confined to the strobe plus one hold cycle, and is never on while the memory is enabled to drive;
- the address holds while data is driven;
- the read pulse lasts one cycle;
- ready stays low during any pin activity.

Only the bench scenarios can show the exact cycle counts: the pulse width in each write style, where the driver starts, the read latency, the float gap and the turnaround cycle. The same holds for whether written data comes back correctly from a model memory.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_RD_FLOAT,
        ST_TURN,
        ST_WR_PULSE,
        ST_WR_HOLD
    } sram_st_t;

    function automatic int ns2cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_cs_split.sv
module sram_cs_split #(
    parameter int          NUM_PINS = 3,
    parameter logic [NUM_PINS-1:0] HIGH_MASK = 3'b010
) (
    input  logic                sel,
    output logic [NUM_PINS-1:0] pins
);
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        if (HIGH_MASK[i]) begin : g_hi
            assign pins[i] = sel;
        end else begin : g_lo
            assign pins[i] = ~sel;
        end
    end
endmodule

// File: rtl/sram_step_counter.sv
module sram_step_counter #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr) q <= '0;
        else               q <= q + 1'b1;
    end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int AW          = 17,
    parameter int DW          = 24,
    parameter int CLK_NS      = 4,
    parameter int T_AA_NS     = 10,
    parameter int T_WP_NS     = 7,
    parameter int T_WP1_NS    = 9,
    parameter int T_DW_NS     = 5,
    parameter int T_OHZ_NS    = 6,
    parameter int T_WHZ_NS    = 5,
    parameter bit KEEP_OE_LOW = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce1_n,
    output logic          mem_ce2,
    output logic          mem_ce3_n,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic [DW-1:0] mem_dq_o,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_i
);
    localparam int RD_N    = ns2cyc(T_AA_NS, CLK_NS);
    localparam int FLT_N   = ns2cyc(T_OHZ_NS, CLK_NS);
    localparam int DW_N    = ns2cyc(T_DW_NS, CLK_NS);
    localparam int WHZ_N   = ns2cyc(T_WHZ_NS, CLK_NS);
    localparam int WPH_N   = imax(ns2cyc(T_WP_NS, CLK_NS), DW_N);
    localparam int WPL_N   = imax(ns2cyc(T_WP1_NS, CLK_NS), WHZ_N + DW_N);
    localparam int PULSE_N = KEEP_OE_LOW ? WPL_N : WPH_N;
    localparam int MAX_N   = imax(imax(RD_N, FLT_N), PULSE_N);
    localparam int CW      = $clog2(MAX_N + 1);
    localparam logic [CW-1:0] RD_LAST    = CW'(RD_N - 1);
    localparam logic [CW-1:0] FLT_LAST   = CW'(FLT_N - 1);
    localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_N - 1);

    sram_st_t      state, state_nxt;
    logic [CW-1:0] cnt;
    logic          cnt_clr;
    logic          accept;
    logic          last_rd;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic          sel;
    logic          oe_act;
    logic          drv;
    logic [2:0]    cs_pins;

    assign accept = (state == ST_IDLE) && req_valid;

    sram_step_counter #(.W(CW)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cnt_clr),
        .q    (cnt)
    );

    always_comb begin
        state_nxt = state;
        cnt_clr   = 1'b0;
        unique case (state)
            ST_IDLE: if (req_valid) begin
                cnt_clr = 1'b1;
                if (!req_we)     state_nxt = ST_RD_ACC;
                else if (last_rd) state_nxt = ST_TURN;
                else             state_nxt = ST_WR_PULSE;
            end
            ST_RD_ACC: if (cnt == RD_LAST) begin
                state_nxt = ST_RD_FLOAT;
                cnt_clr   = 1'b1;
            end
            ST_RD_FLOAT: if (cnt == FLT_LAST) begin
                state_nxt = ST_IDLE;
                cnt_clr   = 1'b1;
            end
            ST_TURN: begin
                state_nxt = ST_WR_PULSE;
                cnt_clr   = 1'b1;
            end
            ST_WR_PULSE: if (cnt == PULSE_LAST) begin
                state_nxt = ST_WR_HOLD;
                cnt_clr   = 1'b1;
            end
            ST_WR_HOLD: begin
                state_nxt = ST_IDLE;
                cnt_clr   = 1'b1;
            end
            default: begin
                state_nxt = ST_IDLE;
                cnt_clr   = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            last_rd   <= 1'b0;
            addr_q    <= '0;
            wdata_q   <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            state     <= state_nxt;
            rsp_valid <= (state == ST_RD_ACC) && (cnt == RD_LAST);
            if ((state == ST_RD_ACC) && (cnt == RD_LAST)) rsp_rdata <= mem_dq_i;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                last_rd <= !req_we;
            end
        end
    end

    // output decode
    always_comb begin
        sel      = (state == ST_RD_ACC) || (state == ST_WR_PULSE);
        mem_we_n = !(state == ST_WR_PULSE);
        mem_oe_n = !oe_act;
    end

    if (KEEP_OE_LOW) begin : g_oe_low
        localparam logic [CW-1:0] DRV_FIRST = CW'(WHZ_N);
        assign oe_act = (state == ST_RD_ACC) || (state == ST_WR_PULSE);
        assign drv    = ((state == ST_WR_PULSE) && (cnt >= DRV_FIRST)) ||
                        (state == ST_WR_HOLD);
    end else begin : g_oe_high
        assign oe_act = (state == ST_RD_ACC);
        assign drv    = (state == ST_WR_PULSE) || (state == ST_WR_HOLD);
    end

    sram_cs_split #(.NUM_PINS(3), .HIGH_MASK(3'b010)) u_cs (
        .sel (sel),
        .pins(cs_pins)
    );

    assign mem_ce1_n = cs_pins[0];
    assign mem_ce2   = cs_pins[1];
    assign mem_ce3_n = cs_pins[2];
    assign mem_dq_oe = drv;
    assign mem_dq_o  = wdata_q;
    assign mem_addr  = addr_q;
    assign req_ready = (state == ST_IDLE);

endmodule

module sram_async_ctrl_chk #(
    parameter int AW = 17
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ce1_n,
    input logic          mem_ce2,
    input logic          mem_ce3_n,
    input logic          mem_we_n,
    input logic          mem_oe_n,
    input logic          mem_dq_oe
);
    p_cs_agree_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ce1_n == mem_ce3_n) && (mem_ce2 == !mem_ce1_n));

    p_we_in_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce1_n && mem_ce2 && !mem_ce3_n));

    p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_addr));

    p_rsp_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_drv_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n || $past(!mem_we_n)));

    p_no_contention_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n && mem_we_n) |-> !mem_dq_oe);

    p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce1_n || mem_dq_oe) |-> !req_ready);
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .mem_addr (mem_addr),
    .mem_ce1_n(mem_ce1_n),
    .mem_ce2  (mem_ce2),
    .mem_ce3_n(mem_ce3_n),
    .mem_we_n (mem_we_n),
    .mem_oe_n (mem_oe_n),
    .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_model.sv
module sram_model (
    input  logic        clk,
    input  logic [16:0] addr,
    input  logic        ce1_n,
    input  logic        ce2,
    input  logic        ce3_n,
    input  logic        we_n,
    input  logic        oe_n,
    input  logic [23:0] din,
    input  logic        din_oe,
    output logic [23:0] dout,
    output int          n_contention
);
    logic [23:0] mem [int];
    logic        sel;
    logic        wr_q;
    logic        pend_ok;
    logic [23:0] pend;
    logic [16:0] pend_addr;

    assign sel = !ce1_n && ce2 && !ce3_n;

    always_comb begin
        dout = '0;
        if (sel && !oe_n && we_n && mem.exists(int'(addr))) dout = mem[int'(addr)];
    end

    initial begin
        n_contention = 0;
        wr_q = 1'b0;
        pend_ok = 1'b0;
        pend = '0;
        pend_addr = '0;
    end

    always @(posedge clk) begin
        if (sel && !oe_n && we_n && din_oe) n_contention = n_contention + 1;
        if (sel && !we_n) begin
            if (din_oe) begin
                pend      = din;
                pend_addr = addr;
                pend_ok   = 1'b1;
            end
        end else if (wr_q) begin
            if (pend_ok) mem[int'(pend_addr)] = pend;
            pend_ok = 1'b0;
        end
        wr_q = sel && !we_n;
    end
endmodule

// File: tb/sram_async_ctrl_tb.sv
module sram_async_ctrl_tb;
    localparam int CLK_PERIOD = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        rv    [2];
    logic        rdy   [2];
    logic        rwe   [2];
    logic [16:0] raddr [2];
    logic [23:0] rwd   [2];
    logic        sv    [2];
    logic [23:0] srd   [2];
    logic [16:0] maddr [2];
    logic        ce1n  [2];
    logic        ce2   [2];
    logic        ce3n  [2];
    logic        wen   [2];
    logic        oen   [2];
    logic [23:0] dqo   [2];
    logic        dqoe  [2];
    logic [23:0] dqi   [2];
    int          ncont [2];

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    sram_async_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(rv[0]), .req_ready(rdy[0]),
        .req_we(rwe[0]), .req_addr(raddr[0]), .req_wdata(rwd[0]),
        .rsp_valid(sv[0]), .rsp_rdata(srd[0]), .mem_addr(maddr[0]),
        .mem_ce1_n(ce1n[0]), .mem_ce2(ce2[0]), .mem_ce3_n(ce3n[0]),
        .mem_we_n(wen[0]), .mem_oe_n(oen[0]), .mem_dq_o(dqo[0]),
        .mem_dq_oe(dqoe[0]), .mem_dq_i(dqi[0])
    );

    sram_async_ctrl #(.KEEP_OE_LOW(1'b1)) u_dut_oel (
        .clk(clk), .rst_n(rst_n), .req_valid(rv[1]), .req_ready(rdy[1]),
        .req_we(rwe[1]), .req_addr(raddr[1]), .req_wdata(rwd[1]),
        .rsp_valid(sv[1]), .rsp_rdata(srd[1]), .mem_addr(maddr[1]),
        .mem_ce1_n(ce1n[1]), .mem_ce2(ce2[1]), .mem_ce3_n(ce3n[1]),
        .mem_we_n(wen[1]), .mem_oe_n(oen[1]), .mem_dq_o(dqo[1]),
        .mem_dq_oe(dqoe[1]), .mem_dq_i(dqi[1])
    );

    sram_model u_mem0 (.clk(clk), .addr(maddr[0]), .ce1_n(ce1n[0]), .ce2(ce2[0]),
        .ce3_n(ce3n[0]), .we_n(wen[0]), .oe_n(oen[0]), .din(dqo[0]),
        .din_oe(dqoe[0]), .dout(dqi[0]), .n_contention(ncont[0]));

    sram_model u_mem1 (.clk(clk), .addr(maddr[1]), .ce1_n(ce1n[1]), .ce2(ce2[1]),
        .ce3_n(ce3n[1]), .we_n(wen[1]), .oe_n(oen[1]), .din(dqo[1]),
        .din_oe(dqoe[1]), .dout(dqi[1]), .n_contention(ncont[1]));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            check(1'b0, "watchdog", cycles, 20000);
            finish_run();
        end
    end

    function automatic bit sel_ok(input int d);
        return !ce1n[d] && ce2[d] && !ce3n[d];
    endfunction

    function automatic bit idle_pins(input int d);
        return ce1n[d] && !ce2[d] && ce3n[d];
    endfunction

    // R1: state after reset
    task automatic t_reset(input int d);
        @(negedge clk);
        check(rdy[d] == 1'b1, "R1 ready", int'(rdy[d]), 1);
        check(idle_pins(d), "R1 selects", {ce1n[d], ce2[d], ce3n[d]}, 3'b101);
        check(wen[d] && oen[d], "R1 strobes", {wen[d], oen[d]}, 2'b11);
        check(!dqoe[d] && !sv[d], "R1 driver/rsp", {dqoe[d], sv[d]}, 0);
    endtask

    // R2 R3 R4 R6 R7 R9 R10: one write
    task automatic t_write(input int d, input logic [16:0] a, input logic [23:0] v,
                           input int exp_delay);
        int idx = 1, first_low = -1, pulse = 0, first_drv = -1, hold = 0;
        int rsp = 0, bad_sel = 0, bad_addr = 0, bad_oe = 0, busy = 0;
        while (!rdy[d]) @(negedge clk);
        rv[d] = 1'b1; rwe[d] = 1'b1; raddr[d] = a; rwd[d] = v;
        @(posedge clk);
        @(negedge clk);
        rv[d] = 1'b0;
        while (!rdy[d]) begin
            busy++;
            if (sv[d]) rsp++;
            if (!idle_pins(d) && !sel_ok(d)) bad_sel++;
            if ((dqoe[d] || !wen[d]) && maddr[d] != a) bad_addr++;
            if (!wen[d]) begin
                if (!sel_ok(d)) bad_sel++;
                if (first_low < 0) first_low = idx;
                if (dqoe[d] && first_drv < 0) first_drv = pulse;
                if (oen[d] != (d == 0)) bad_oe++;
                pulse++;
            end else if (dqoe[d]) hold++;
            @(negedge clk);
            idx++;
        end
        check(first_low == exp_delay, "R9 strobe delay", first_low, exp_delay);
        check(pulse == ((d == 0) ? 2 : 4), (d == 0) ? "R6 pulse" : "R7 pulse",
              pulse, (d == 0) ? 2 : 4);
        check(first_drv == ((d == 0) ? 0 : 2), (d == 0) ? "R6 drv start" : "R7 drv start",
              first_drv, (d == 0) ? 0 : 2);
        check(hold == 1, "R6 hold", hold, 1);
        check(bad_oe == 0, (d == 0) ? "R6 oe high" : "R7 oe low", bad_oe, 0);
        check(bad_sel == 0, "R2 R3 select", bad_sel, 0);
        check(bad_addr == 0, "R4 address", bad_addr, 0);
        check(rsp == 0, "R10 no rsp on write", rsp, 0);
        check(busy == exp_delay + ((d == 0) ? 2 : 4), "R10 busy",
              busy, exp_delay + ((d == 0) ? 2 : 4));
    endtask

    // R3 R5 R8 R10: one read
    task automatic t_read(input int d, input logic [16:0] a, input logic [23:0] exp);
        int idx = 1, rsp_idx = -1, nrsp = 0, oe_low = 0, flt = 0, bad_addr = 0;
        logic [23:0] got = '0;
        while (!rdy[d]) @(negedge clk);
        rv[d] = 1'b1; rwe[d] = 1'b0; raddr[d] = a; rwd[d] = '0;
        @(posedge clk);
        @(negedge clk);
        rv[d] = 1'b0;
        while (!rdy[d]) begin
            if (sv[d]) begin nrsp++; rsp_idx = idx; got = srd[d]; end
            if (!oen[d] && wen[d] && sel_ok(d)) begin
                oe_low++;
                if (maddr[d] != a) bad_addr++;
            end else if (oe_low > 0 && oen[d]) flt++;
            @(negedge clk);
            idx++;
        end
        check(oe_low == 3, "R5 access cycles", oe_low, 3);
        check(rsp_idx == 4 && nrsp == 1, "R5 rsp pulse", rsp_idx, 4);
        check(got == exp, "R3 R5 read data", int'(got), int'(exp));
        check(flt == 2, "R8 float gap", flt, 2);
        check(bad_addr == 0, "R4 read address", bad_addr, 0);
    endtask

    task automatic t_scenario(input int d);
        t_reset(d);
        t_write(d, 17'h00012, 24'hA5C3E1, 1);
        t_write(d, 17'h1FFFF, 24'hFFFFFF, 1);
        t_read(d, 17'h00012, 24'hA5C3E1);
        t_write(d, 17'h00000, 24'h00F00D, 2);
        t_read(d, 17'h1FFFF, 24'hFFFFFF);
        t_read(d, 17'h00000, 24'h00F00D);
        t_write(d, 17'h00012, 24'h5A3C1E, 2);
        t_write(d, 17'h00013, 24'h000001, 1);
        t_read(d, 17'h00012, 24'h5A3C1E);
        t_read(d, 17'h00013, 24'h000001);
        check(ncont[d] == 0, "R8 contention", ncont[d], 0);
    endtask

    initial begin
        for (int d = 0; d < 2; d++) begin
            rv[d] = 1'b0; rwe[d] = 1'b0; raddr[d] = '0; rwd[d] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_scenario(0);
        t_scenario(1);
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule